// File: doc/BRIEF.md
# Package Idle State Resolver

This block turns the idle-state reports of a set of cores into one idle state for the whole package. Every cycle it finds the shallowest state that any core reports. It then limits that state to the deepest coordinated state the platform currently allows, and registers the result as the package state. Independent states (C0, C1, C1E) need no platform permission. Coordinated states (C2, C3, C6) are never entered deeper than the platform's limit. The package can move straight from one idle state to another without passing through C0.

The block also handles wake-ups. A core break names a target core and carries a mask bit. The target core always gets a one-cycle wake pulse and the package drops to C0. If the break is masked, the package then goes back to the state it held before the break. A memory or snoop break raises a one-cycle service grant with the package in C0. Afterwards the package either returns to its prior state or, while the platform asks for it, stays in C0. At most one break is acted on per cycle, and a core break wins over a memory break.

Top module: `idle_pkg_resolver`

## Requirements
- R1: State codes are 3 bits ordered by depth: C0=0, C1=1, C1E=2, C2=3, C3=4, C6=5. With no break in progress, the package state one cycle after the inputs are applied is the shallowest core code, capped as in R3.
- R2: Core or platform codes 6 and 7 are treated as C6 (5).
- R3: The platform limit caps only coordinated states. The package state equals min(shallowest core code, max(platform limit, C1E)).
- R4: The package moves between two idle states in a single cycle without an intervening C0.
- R5: An unmasked core break taken while the package is idle gives, on the next cycle, package C0 and a wake vector with only the target bit set. On the cycle after that the wake vector is zero and normal resolution resumes.
- R6: A masked core break gives the same wake pulse and one cycle of C0. On the following cycle the package shows the state it held before the break.
- R7: A memory/snoop break with the hold request low gives one cycle of service grant with package C0. On the following cycle the package shows its prior state again.
- R8: A memory/snoop break with the hold request high gives the grant with package C0. The package stays in C0 while the hold request is high, and shows its prior state on the cycle after the hold request drops.
- R9: When a core break and a memory break arrive together, only the core break is acted on, and no service grant is raised.
- R10: Breaks arriving while the package is in C0 are ignored. This includes the C0 cycles of a break being serviced: no wake bit and no grant follow.
- R11: While reset is held, the package state is C0 and the wake vector and service grant are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_codes | input | 3*N_CORES | Per-core idle state codes, core k in bits [3k+2:3k] |
| plat_limit | input | 3 | Deepest coordinated state the platform allows |
| plat_hold | input | 1 | Platform asks to keep the package shallow after a memory break |
| cbrk_valid | input | 1 | Core break event present |
| cbrk_core | input | IDW | Target core index of the core break |
| cbrk_masked | input | 1 | Core break is masked |
| mbrk_valid | input | 1 | Memory access or snoop break present |
| pkg_code | output | 3 | Resolved package idle state |
| wake_vec | output | N_CORES | One-cycle wake pulse per core |
| svc_grant | output | 1 | One-cycle grant to service a memory/snoop break |

## Verification
The assertions check on every cycle that the wake vector is one-hot or zero and that a wake or grant appears only with the package in C0. They also check that wake and grant never coincide, that a resolved state is never deeper than the shallowest core or, for coordinated states, the platform limit, and that the restore and hold phases produce the prior state and C0. Only the bench scenarios show the exact resolved values across all code combinations, the exact state restored after each kind of break, the priority of a simultaneous core break, and the dropping of breaks that arrive during C0.

// File: rtl/idle_pkg.sv
package idle_pkg;

    localparam int unsigned CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        PS_C0  = 3'd0,
        PS_C1  = 3'd1,
        PS_C1E = 3'd2,
        PS_C2  = 3'd3,
        PS_C3  = 3'd4,
        PS_C6  = 3'd5
    } pstate_e;

    typedef enum logic [1:0] {
        MD_RUN,
        MD_RESTORE,
        MD_HOLD
    } mode_e;

    typedef enum logic [1:0] {
        BK_NONE,
        BK_CORE_LIVE,
        BK_CORE_MASKED,
        BK_MEM
    } brk_kind_e;

    // Out-of-range codes fold to the deepest supported state.
    function automatic pstate_e clamp_code(logic [CODE_W-1:0] raw);
        return (raw > 3'd5) ? PS_C6 : pstate_e'(raw);
    endfunction

    function automatic pstate_e shallower(pstate_e a, pstate_e b);
        return (a < b) ? a : b;
    endfunction

    // Independent states never need permission, so the cap is at least C1E.
    function automatic pstate_e permit_cap(logic [CODE_W-1:0] raw);
        pstate_e s;
        s = clamp_code(raw);
        return (s < PS_C1E) ? PS_C1E : s;
    endfunction

endpackage

// File: rtl/idle_min_tree.sv
module idle_min_tree
    import idle_pkg::*;
#(
    parameter int unsigned N_CORES = 4
) (
    input  logic [N_CORES*CODE_W-1:0] codes,
    output pstate_e                   shallowest
);
    pstate_e chain [N_CORES];

    generate
        for (genvar i = 0; i < N_CORES; i++) begin : g_fold
            if (i == 0) begin : g_first
                assign chain[i] = clamp_code(codes[CODE_W-1:0]);
            end else begin : g_next
                assign chain[i] = shallower(chain[i-1],
                                            clamp_code(codes[i*CODE_W +: CODE_W]));
            end
        end
    endgenerate

    assign shallowest = chain[N_CORES-1];
endmodule

// File: rtl/idle_break_arb.sv
module idle_break_arb
    import idle_pkg::*;
#(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned IDW     = 2
) (
    input  logic               accept,
    input  logic               cbrk_valid,
    input  logic [IDW-1:0]     cbrk_core,
    input  logic               cbrk_masked,
    input  logic               mbrk_valid,
    input  logic               hold_req,
    output brk_kind_e          kind,
    output mode_e              next_mode,
    output logic [N_CORES-1:0] wake_onehot
);
    always_comb begin
        kind      = BK_NONE;
        next_mode = MD_RUN;
        if (accept) begin
            if (cbrk_valid) begin
                kind      = cbrk_masked ? BK_CORE_MASKED : BK_CORE_LIVE;
                next_mode = cbrk_masked ? MD_RESTORE : MD_RUN;
            end else if (mbrk_valid) begin
                kind      = BK_MEM;
                next_mode = hold_req ? MD_HOLD : MD_RESTORE;
            end
        end
    end

    generate
        for (genvar k = 0; k < N_CORES; k++) begin : g_dec
            assign wake_onehot[k] = (kind == BK_CORE_LIVE || kind == BK_CORE_MASKED)
                                    && (cbrk_core == IDW'(k));
        end
    endgenerate
endmodule

// File: rtl/idle_pkg_resolver.sv
module idle_pkg_resolver
    import idle_pkg::*;
#(
    parameter int unsigned N_CORES = 4,
    localparam int unsigned IDW    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CORES*CODE_W-1:0] core_codes,
    input  logic [CODE_W-1:0]         plat_limit,
    input  logic                      plat_hold,
    input  logic                      cbrk_valid,
    input  logic [IDW-1:0]            cbrk_core,
    input  logic                      cbrk_masked,
    input  logic                      mbrk_valid,
    output logic [CODE_W-1:0]         pkg_code,
    output logic [N_CORES-1:0]        wake_vec,
    output logic                      svc_grant
);
    pstate_e            floor_st;
    pstate_e            cap_st;
    pstate_e            target_st;
    pstate_e            pkg_q;
    pstate_e            prev_q;
    mode_e              mode_q;
    mode_e              brk_mode;
    brk_kind_e          kind;
    logic               accept;
    logic [N_CORES-1:0] wake_d;
    logic [N_CORES-1:0] wake_q;
    logic               grant_q;

    idle_min_tree #(.N_CORES(N_CORES)) min_i (
        .codes      (core_codes),
        .shallowest (floor_st)
    );

    assign cap_st    = permit_cap(plat_limit);
    assign target_st = shallower(floor_st, cap_st);
    assign accept    = (mode_q == MD_RUN) && (pkg_q != PS_C0);

    idle_break_arb #(.N_CORES(N_CORES), .IDW(IDW)) arb_i (
        .accept      (accept),
        .cbrk_valid  (cbrk_valid),
        .cbrk_core   (cbrk_core),
        .cbrk_masked (cbrk_masked),
        .mbrk_valid  (mbrk_valid),
        .hold_req    (plat_hold),
        .kind        (kind),
        .next_mode   (brk_mode),
        .wake_onehot (wake_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pkg_q   <= PS_C0;
            prev_q  <= PS_C0;
            mode_q  <= MD_RUN;
            wake_q  <= '0;
            grant_q <= 1'b0;
        end else begin
            wake_q  <= '0;
            grant_q <= 1'b0;
            unique case (mode_q)
                MD_RUN: begin
                    if (kind == BK_NONE) begin
                        pkg_q <= target_st;
                    end else begin
                        prev_q  <= pkg_q;
                        pkg_q   <= PS_C0;
                        mode_q  <= brk_mode;
                        wake_q  <= wake_d;
                        grant_q <= (kind == BK_MEM);
                    end
                end
                MD_RESTORE: begin
                    pkg_q  <= prev_q;
                    mode_q <= MD_RUN;
                end
                MD_HOLD: begin
                    if (!plat_hold) begin
                        pkg_q  <= prev_q;
                        mode_q <= MD_RUN;
                    end
                end
                default: mode_q <= MD_RUN;
            endcase
        end
    end

    assign pkg_code  = pkg_q;
    assign wake_vec  = wake_q;
    assign svc_grant = grant_q;

    // R1: a resolved state never lies deeper than the shallowest core.
    a_r1_not_deeper: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_RUN && kind == BK_NONE) |=> (pkg_q <= $past(floor_st)));

    // R3: coordinated states stay within the platform limit.
    a_r3_within_cap: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_RUN && kind == BK_NONE) |=>
            (pkg_q <= PS_C1E || pkg_q <= $past(clamp_code(plat_limit))));

    // R5: at most one core woken per cycle.
    a_r5_wake_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wake_q));

    // R10: wake and grant appear only with the package active.
    a_r10_pulse_in_c0: assert property (@(posedge clk) disable iff (rst)
        (wake_q != '0 || grant_q) |-> (pkg_q == PS_C0));

    // R6/R7: restore phase reloads the saved state.
    a_r6_restore_prev: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_RESTORE) |=> (pkg_q == $past(prev_q)));

    // R8: hold keeps the package active.
    a_r8_hold_c0: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_HOLD && plat_hold) |=> (pkg_q == PS_C0));

    // R9: one break per cycle, so wake and grant never coincide.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(grant_q && wake_q != '0));
endmodule

// File: tb/idle_pkg_resolver_tb.sv
module idle_pkg_resolver_tb_top;
    localparam int N   = 4;
    localparam int IDW = 2;

    logic           clk = 1'b0;
    logic           rst;
    logic [N*3-1:0] core_codes;
    logic [2:0]     plat_limit;
    logic           plat_hold;
    logic           cbrk_valid;
    logic [IDW-1:0] cbrk_core;
    logic           cbrk_masked;
    logic           mbrk_valid;
    logic [2:0]     pkg_code;
    logic [N-1:0]   wake_vec;
    logic           svc_grant;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    idle_pkg_resolver #(.N_CORES(N)) dut_i (
        .clk(clk), .rst(rst), .core_codes(core_codes), .plat_limit(plat_limit),
        .plat_hold(plat_hold), .cbrk_valid(cbrk_valid), .cbrk_core(cbrk_core),
        .cbrk_masked(cbrk_masked), .mbrk_valid(mbrk_valid),
        .pkg_code(pkg_code), .wake_vec(wake_vec), .svc_grant(svc_grant)
    );

    function automatic int sat(int c);
        return (c > 5) ? 5 : c;
    endfunction

    function automatic int model(logic [N*3-1:0] cc, logic [2:0] pl);
        int m = 5;
        int cap;
        for (int k = 0; k < N; k++) if (sat(int'(cc[k*3 +: 3])) < m) m = sat(int'(cc[k*3 +: 3]));
        cap = (sat(int'(pl)) < 2) ? 2 : sat(int'(pl));
        return (m < cap) ? m : cap;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic all_cores(int code);
        for (int k = 0; k < N; k++) core_codes[k*3 +: 3] = 3'(code);
    endtask

    task automatic clear_brk();
        cbrk_valid = 0; cbrk_masked = 0; mbrk_valid = 0; cbrk_core = '0;
    endtask

    // Park the package at C3: all cores C6, platform limit C3 (code 4).
    task automatic park_c3();
        all_cores(5); plat_limit = 3'd4; plat_hold = 0; clear_brk();
        tick(); tick();
        chk("R3 park", int'(pkg_code), 4);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; all_cores(5); plat_limit = 3'd7; plat_hold = 0; clear_brk();
        tick(); tick();
        chk("R11 pkg", int'(pkg_code), 0);
        chk("R11 wake", int'(wake_vec), 0);
        chk("R11 grant", int'(svc_grant), 0);
        rst = 0;

        // R1 R2 R3: sweep every core combination and platform limit.
        for (int c = 0; c < 4096; c++) begin
            for (int p = 0; p < 8; p++) begin
                core_codes = 12'(c);
                plat_limit = 3'(p);
                tick();
                chk("R1/R2/R3 sweep", int'(pkg_code), model(12'(c), 3'(p)));
            end
        end

        // R2: all codes 7 with limit 7 resolve to C6.
        all_cores(7); plat_limit = 3'd7; tick();
        chk("R2 fold", int'(pkg_code), 5);

        // R4: C3 directly to C1E.
        all_cores(4); tick();
        chk("R4 deep", int'(pkg_code), 4);
        all_cores(2); tick();
        chk("R4 direct", int'(pkg_code), 2);

        // R6: masked core break.
        park_c3();
        cbrk_valid = 1; cbrk_masked = 1; cbrk_core = 2'd2; tick();
        chk("R6 c0", int'(pkg_code), 0);
        chk("R6 wake", int'(wake_vec), 4);
        clear_brk(); tick();
        chk("R6 restore", int'(pkg_code), 4);
        chk("R6 wake off", int'(wake_vec), 0);

        // R5: unmasked core break.
        park_c3();
        cbrk_valid = 1; cbrk_core = 2'd1; tick();
        chk("R5 c0", int'(pkg_code), 0);
        chk("R5 wake", int'(wake_vec), 2);
        clear_brk(); core_codes[3 +: 3] = 3'd0; tick();
        chk("R5 resolve", int'(pkg_code), 0);
        chk("R5 wake off", int'(wake_vec), 0);
        core_codes[3 +: 3] = 3'd5; tick();
        chk("R5 reenter", int'(pkg_code), 4);

        // R7: memory break, no hold.
        park_c3();
        mbrk_valid = 1; tick();
        chk("R7 c0", int'(pkg_code), 0);
        chk("R7 grant", int'(svc_grant), 1);
        clear_brk(); tick();
        chk("R7 restore", int'(pkg_code), 4);
        chk("R7 grant off", int'(svc_grant), 0);

        // R8: memory break with hold.
        park_c3();
        plat_hold = 1; mbrk_valid = 1; tick();
        chk("R8 grant", int'(svc_grant), 1);
        chk("R8 c0", int'(pkg_code), 0);
        clear_brk(); tick();
        chk("R8 held", int'(pkg_code), 0);
        tick();
        chk("R8 still held", int'(pkg_code), 0);
        plat_hold = 0; tick();
        chk("R8 release", int'(pkg_code), 4);

        // R9: simultaneous breaks, core wins.
        park_c3();
        cbrk_valid = 1; cbrk_masked = 1; cbrk_core = 2'd3; mbrk_valid = 1; tick();
        chk("R9 wake", int'(wake_vec), 8);
        chk("R9 no grant", int'(svc_grant), 0);
        clear_brk(); tick();
        chk("R9 restore", int'(pkg_code), 4);

        // R10: break during the restore cycle is dropped.
        park_c3();
        cbrk_valid = 1; cbrk_masked = 1; cbrk_core = 2'd0; tick();
        clear_brk(); mbrk_valid = 1; tick();
        chk("R10 restore", int'(pkg_code), 4);
        chk("R10 no grant", int'(svc_grant), 0);
        clear_brk();

        // R10: breaks while resolved C0 are ignored.
        all_cores(0); tick();
        chk("R10 active", int'(pkg_code), 0);
        cbrk_valid = 1; cbrk_core = 2'd0; mbrk_valid = 1; tick();
        chk("R10 no wake", int'(wake_vec), 0);
        chk("R10 no grant c0", int'(svc_grant), 0);
        clear_brk(); all_cores(5); tick();
        chk("R10 idle resumes", int'(pkg_code), 4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule